// File: doc/BRIEF.md
# Hyperframe Test Pattern Generator (64b/66b line rates)

This block produces a repeating framed test pattern on a 64-bit data bus with one control bit per byte lane. It is meant to drive the transmit side of a 64b/66b link during bring-up and latency measurement. Each hyperframe opens with one synchronization beat, in which lane 0 carries a control character and lane 1 carries a running hyperframe number. The rest of the hyperframe is a run of data beats that carry an incrementing counter.

The hyperframe length in beats is `BF_PER_HF * 2 * W`. `W` is a word width in bytes that is chosen by the 4-bit rate-select input. A simulation option cuts every hyperframe to a quarter of that length. A one-cycle start pulse marks the synchronization beat, so a matching receiver can time the link. The rate select is sampled only when a hyperframe begins. This keeps a running hyperframe intact when the rate changes.

Top module: `hf_pattern_gen`

## Requirements
- R1: While `rst` is high, `tx_data`, `tx_ctrl` and `start` are all zero at once, without waiting for a clock. The first beat after `rst` falls is a synchronization beat with hyperframe number 0.
- R2: In a synchronization beat, bits [7:0] of `tx_data` equal `SYNC_CHAR` (default 8'hFB). Bits [15:8] hold the hyperframe number, zero-extended. All higher bits are zero, and `tx_ctrl` equals 1 (only lane 0 marked as control).
- R3: In every data beat, `tx_ctrl` is zero. The first data beat after a synchronization beat carries 0, and each later data beat carries the previous value plus 1.
- R4: A hyperframe spans `BF_PER_HF*2*W` beats, including its synchronization beat. `W` depends on `rate_sel`: code 0 gives 4, code 1 gives 5, code 2 gives 8, code 3 gives 10, and codes 4 to 15 give 16.
- R5: With `SIM_MODE` set, every hyperframe spans a quarter of the length given in R4.
- R6: `start` is high for exactly the one cycle that carries each synchronization beat, and low in every data beat.
- R7: The length of a hyperframe comes from the `rate_sel` value sampled at the clock edge that emits its synchronization beat. Changes to `rate_sel` at any other time do not alter the running hyperframe.
- R8: The hyperframe number increases by 1 from one hyperframe to the next and wraps modulo 2^`HFN_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Asynchronous reset, active high |
| rate_sel | input | 4 | Line-rate code that selects the word width |
| tx_data | output | DATA_W | Pattern data, lane 0 in bits [7:0] |
| tx_ctrl | output | DATA_W/8 | Per-lane control marker |
| start | output | 1 | One-cycle pulse on each synchronization beat |

## Verification
The bench steps `rate_sel` through all sixteen codes in turn. It checks every beat of each hyperframe against a counter kept in the bench, so a wrong code-to-width mapping shows up as a misplaced synchronization beat. In each hyperframe the bench first drives an unrelated code and then the next wanted code halfway through. A design that samples the rate anywhere other than the frame boundary therefore fails the length check. Eighteen hyperframes are enough to pass the wrap of a 3-bit hyperframe number. A second instance with the shortened mode is compared against the full-length one on a held code, using both the pulse period and the last counter value. A reset in the middle of the run shows the outputs clearing at once and the numbering starting again from zero.

// File: rtl/hfgen_pkg.sv
package hfgen_pkg;

   localparam int unsigned MAX_WORD_BYTES = 16;

   typedef logic [3:0] rate_code_t;

   // Word width in bytes selected by a rate code.
   function automatic int unsigned word_bytes(input rate_code_t code);
      int unsigned w;
      case (code)
         4'd0:    w = 4;
         4'd1:    w = 5;
         4'd2:    w = 8;
         4'd3:    w = 10;
         default: w = MAX_WORD_BYTES;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/hfgen_len_calc.sv
module hfgen_len_calc
   import hfgen_pkg::*;
#(
   parameter int BF_PER_HF = 256,
   parameter int SIM_MODE  = 0,
   parameter int LEN_W     = 14
) (
   input  logic [3:0]       rate_sel,
   output logic [LEN_W-1:0] hf_len
);

   logic [LEN_W-1:0] full_len;

   always_comb begin
      full_len = LEN_W'(BF_PER_HF * 2 * word_bytes(rate_sel));
   end

   generate
      if (SIM_MODE != 0) begin : g_short
         assign hf_len = full_len >> 2;
      end else begin : g_full
         assign hf_len = full_len;
      end
   endgenerate

endmodule

// File: rtl/hfgen_seq.sv
module hfgen_seq #(
   parameter int LEN_W = 14,
   parameter int HFN_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [LEN_W-1:0] next_len,
   output logic             is_sync,
   output logic [HFN_W-1:0] hfn
);

   logic [LEN_W-1:0] pos_q;
   logic [LEN_W-1:0] len_q;
   logic [HFN_W-1:0] hfn_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         pos_q <= '0;
         len_q <= '0;
         hfn_q <= '0;
      end else if (pos_q == '0) begin
         len_q <= next_len;
         pos_q <= LEN_W'(1);
         hfn_q <= hfn_q + 1'b1;
      end else if (pos_q == len_q - 1'b1) begin
         pos_q <= '0;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign is_sync = (pos_q == '0);
   assign hfn     = hfn_q;

   AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
      (pos_q != '0) |-> (pos_q < len_q)); // R4

   AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
      (pos_q != '0) |=> $stable(len_q)); // R7

   AST_HFN_STEP: assert property (@(posedge clk) disable iff (rst)
      is_sync |=> (hfn_q == HFN_W'($past(hfn_q) + 1'b1))); // R8

endmodule

// File: rtl/hfgen_beat.sv
module hfgen_beat #(
   parameter int         DATA_W    = 64,
   parameter int         HFN_W     = 8,
   parameter logic [7:0] SYNC_CHAR = 8'hFB
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                is_sync,
   input  logic [HFN_W-1:0]    hfn,
   output logic [DATA_W-1:0]   data_o,
   output logic [DATA_W/8-1:0] ctrl_o,
   output logic                start_o
);

   localparam int LANES = DATA_W / 8;

   logic [DATA_W-1:0] sync_data;
   logic [LANES-1:0]  sync_ctrl;
   logic [DATA_W-1:0] cnt_q;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         if (l == 0) begin : g_char
            assign sync_data[l*8 +: 8] = SYNC_CHAR;
            assign sync_ctrl[l]        = 1'b1;
         end else if (l == 1) begin : g_num
            assign sync_data[l*8 +: 8] = 8'(hfn);
            assign sync_ctrl[l]        = 1'b0;
         end else begin : g_pad
            assign sync_data[l*8 +: 8] = 8'h00;
            assign sync_ctrl[l]        = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         data_o  <= '0;
         ctrl_o  <= '0;
         start_o <= 1'b0;
         cnt_q   <= '0;
      end else if (is_sync) begin
         data_o  <= sync_data;
         ctrl_o  <= sync_ctrl;
         start_o <= 1'b1;
         cnt_q   <= '0;
      end else begin
         data_o  <= cnt_q;
         ctrl_o  <= '0;
         start_o <= 1'b0;
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o); // R6

   AST_START_ON_SYNC: assert property (@(posedge clk) disable iff (rst)
      start_o |-> (data_o[7:0] == SYNC_CHAR && ctrl_o == LANES'(1))); // R2

   AST_DATA_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(start_o) |-> (data_o == '0 && ctrl_o == '0)); // R3

   AST_DATA_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !start_o && !$past(start_o)) |->
      (data_o == $past(data_o) + 1'b1 && ctrl_o == '0)); // R3

endmodule

// File: rtl/hf_pattern_gen.sv
module hf_pattern_gen
   import hfgen_pkg::*;
#(
   parameter int         DATA_W    = 64,
   parameter int         BF_PER_HF = 256,
   parameter int         SIM_MODE  = 0,
   parameter int         HFN_W     = 8,
   parameter logic [7:0] SYNC_CHAR = 8'hFB
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [3:0]          rate_sel,
   output logic [DATA_W-1:0]   tx_data,
   output logic [DATA_W/8-1:0] tx_ctrl,
   output logic                start
);

   localparam int MAX_LEN = BF_PER_HF * 2 * int'(MAX_WORD_BYTES);
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (HFN_W < 1 || HFN_W > 8) begin : g_bad_hfn
         $error("HFN_W must lie in 1..8");
      end
      if (BF_PER_HF < 1) begin : g_bad_bf
         $error("BF_PER_HF must be positive");
      end
      if (SIM_MODE != 0 && BF_PER_HF % 2 != 0) begin : g_bad_sim
         $error("shortened mode needs an even BF_PER_HF");
      end
   endgenerate

   logic [LEN_W-1:0] next_len;
   logic             is_sync;
   logic [HFN_W-1:0] hfn;

   hfgen_len_calc #(
      .BF_PER_HF (BF_PER_HF),
      .SIM_MODE  (SIM_MODE),
      .LEN_W     (LEN_W)
   ) u_len (
      .rate_sel (rate_sel),
      .hf_len   (next_len)
   );

   hfgen_seq #(
      .LEN_W (LEN_W),
      .HFN_W (HFN_W)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .next_len (next_len),
      .is_sync  (is_sync),
      .hfn      (hfn)
   );

   hfgen_beat #(
      .DATA_W    (DATA_W),
      .HFN_W     (HFN_W),
      .SYNC_CHAR (SYNC_CHAR)
   ) u_beat (
      .clk     (clk),
      .rst     (rst),
      .is_sync (is_sync),
      .hfn     (hfn),
      .data_o  (tx_data),
      .ctrl_o  (tx_ctrl),
      .start_o (start)
   );

endmodule

// File: tb/hf_pattern_gen_bench.sv
`timescale 1ns/1ps
module hf_pattern_gen_bench;

   localparam int BF    = 4;
   localparam int HFN_W = 3;
   localparam int NFR   = 18;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  rate_sel = 4'd0;
   logic [63:0] tx_data, s_data;
   logic [7:0]  tx_ctrl, s_ctrl;
   logic        start, s_start;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   hf_pattern_gen #(.DATA_W(64), .BF_PER_HF(BF), .SIM_MODE(0), .HFN_W(HFN_W)) u_hf_pattern_gen (
      .clk(clk), .rst(rst), .rate_sel(rate_sel),
      .tx_data(tx_data), .tx_ctrl(tx_ctrl), .start(start));

   hf_pattern_gen #(.DATA_W(64), .BF_PER_HF(BF), .SIM_MODE(1), .HFN_W(HFN_W)) u_sim (
      .clk(clk), .rst(rst), .rate_sel(rate_sel),
      .tx_data(s_data), .tx_ctrl(s_ctrl), .start(s_start));

   function automatic int wbytes(input logic [3:0] c);
      if (c == 4'd0) return 4;
      if (c == 4'd1) return 5;
      if (c == 4'd2) return 8;
      if (c == 4'd3) return 10;
      return 16;
   endfunction

   function automatic int exp_len(input logic [3:0] c);
      return BF * 2 * wbytes(c);
   endfunction

   function automatic logic [3:0] code_at(input int k);
      if (k < 16) return 4'(k);
      if (k == 16) return 4'd3;
      return 4'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_sync(input int num, input string req);
      chk(start == 1'b1, req, "start on sync beat", 64'(start), 64'd1);
      chk(tx_ctrl == 8'h01, req, "sync ctrl", 64'(tx_ctrl), 64'h01);
      chk(tx_data[7:0] == 8'hFB, req, "sync char", 64'(tx_data[7:0]), 64'hFB);
      chk(tx_data[15:8] == 8'(num), req, "hyperframe number", 64'(tx_data[15:8]), 64'(num));
      chk(tx_data[63:16] == '0, req, "sync padding", 64'(tx_data[63:16]), 64'd0);
   endtask

   task automatic measure(input bit sim, output int cyc, output logic [63:0] last);
      cyc  = 0;
      last = '0;
      do @(negedge clk); while ((sim ? s_start : start) != 1'b1);
      do begin
         if (!(sim ? s_start : start)) last = sim ? s_data : tx_data;
         @(negedge clk);
         cyc++;
      end while ((sim ? s_start : start) != 1'b1);
   endtask

   initial begin
      int cyc;
      logic [63:0] last;
      rate_sel = code_at(0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(tx_data == '0 && tx_ctrl == '0 && start == 1'b0, "R1", "outputs in reset",
          tx_data | 64'(tx_ctrl) | 64'(start), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check_sync(0, "R1");

      // Sweep all rate codes; mid-frame rate changes probe R7
      for (int k = 0; k < NFR; k++) begin
         logic [3:0] cur;
         int         len;
         cur = code_at(k);
         len = exp_len(cur);
         rate_sel = ~cur;
         for (int i = 1; i < len; i++) begin
            @(negedge clk);
            chk(tx_data == 64'(i - 1) && tx_ctrl == '0, "R3", "data beat",
                tx_data, 64'(i - 1));
            chk(start == 1'b0, "R6", "start low in data", 64'(start), 64'd0);
            if (i == len / 2) rate_sel = code_at(k + 1);
         end
         @(negedge clk);
         // frame length (R4, R7) and numbering wrap (R8)
         check_sync((k + 1) % (1 << HFN_W), "R4 R7 R8 R2");
      end

      // Shortened mode against full length (R5)
      rate_sel = 4'd2;
      measure(1'b0, cyc, last);
      measure(1'b0, cyc, last);
      chk(cyc == exp_len(4'd2), "R4", "full period", 64'(cyc), 64'(exp_len(4'd2)));
      chk(last == 64'(exp_len(4'd2) - 2), "R3", "last full count", last, 64'(exp_len(4'd2) - 2));
      measure(1'b1, cyc, last);
      measure(1'b1, cyc, last);
      chk(cyc == exp_len(4'd2) / 4, "R5", "short period", 64'(cyc), 64'(exp_len(4'd2) / 4));
      chk(last == 64'(exp_len(4'd2) / 4 - 2), "R5", "last short count", last,
          64'(exp_len(4'd2) / 4 - 2));
      chk(s_ctrl == 8'h01 && s_data[7:0] == 8'hFB, "R5", "short sync beat",
          64'(s_ctrl), 64'h01);

      // Asynchronous reset mid-frame (R1)
      repeat (5) @(negedge clk);
      #1 rst = 1'b1;
      #0.5;
      chk(tx_data == '0 && tx_ctrl == '0 && start == 1'b0, "R1", "async clear",
          tx_data | 64'(tx_ctrl), 64'd0);
      chk(s_data == '0 && s_start == 1'b0, "R1", "async clear short", s_data, 64'd0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_sync(0, "R1");
      @(negedge clk);
      chk(tx_data == '0 && start == 1'b0, "R3", "first data after reset", tx_data, 64'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule